// File: doc/BRIEF.md
# Serial-Bus Write-Protect Flag Command Handler

This block is an I2C slave command decoder that sits beside a serial EEPROM core. It listens on the two-wire bus for protection commands and keeps two write-protect flags. The first is a sticky protect flag that cannot be cleared once it is set. The second is a reversible protect flag that can be set and cleared. Addresses whose device-type field is anything other than the protection preamble, including ordinary memory-access addresses, are left alone. The memory core handles those.

A master changes a flag with a three-byte write: the address byte, then a dummy byte, then a second dummy byte, then STOP. A master reads a flag with a one-byte query. The answer is carried only by the acknowledge bit of the address byte. Commands for the reversible flag need two qualifiers. The high-voltage detect input for address pin 0 must be asserted before START and held until STOP. The three address-pin levels must match one of three configured patterns. A command that lacks either qualifier is taken as a command for the sticky flag.

Top module: `wp_prot_handler`

## Requirements
- R1: After reset both flags read 0 and the SDA pull-down is released.
- R2: An address byte whose upper four bits differ from 0110 (for example 1010) receives no ACK. It changes no flag.
- R3: A write command has the upper nibble 0110 and a 0 in bit 0 of the address byte. It is followed by two dummy bytes. The address byte and both dummy bytes are ACKed (SDA held low in the ninth clock). The command takes effect at the STOP that follows the third ACK. Without the reversible qualifiers it sets the sticky flag.
- R4: A query command has a 1 in bit 0 of the address byte. The ninth clock after the address is ACKed when the selected flag is 0 and NACKed when it is 1. SDA is then released and no data is driven.
- R5: With the high-voltage qualifier held from START through STOP, the address-pin pattern selects the reversible flag. Pattern 001 sets it on a write and pattern 011 clears it on a write. Pattern 101 queries it. These are the default parameter values.
- R6: If the high-voltage qualifier is low at START, or falls at any point before STOP, the command is treated as a sticky-flag command.
- R7: Once the sticky flag is 1, nothing except reset returns it to 0.
- R8: While the sticky flag is 1, reversible set or clear writes receive a NACK on the second dummy byte. The reversible flag keeps its value.
- R9: A repeated START or a STOP that comes before the third ACK aborts the write. Neither flag changes.
- R10: The SDA pull-down changes state only while SCL is low.
- R11: If the master clocks further bits after the third ACK instead of issuing STOP, the write is aborted. No flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronised serial clock |
| sdaIn | input | 1 | Synchronised serial data (resolved bus level) |
| addrPins | input | 3 | Levels on the three address pins |
| hvDetect | input | 1 | High-voltage present on address pin 0 |
| sdaPullDown | output | 1 | 1 pulls SDA low (acknowledge) |
| permFlag | output | 1 | Sticky protect flag |
| revFlag | output | 1 | Reversible protect flag |

## Verification
The hardest situations to reach are those where the qualifier or the framing changes partway through a command. In these the same bytes end differently, depending on when the high-voltage input moved or whether the master ended with STOP. The bench reaches them with a bit-level master. It can raise or drop the high-voltage input between the address byte and the dummy bytes. It can also insert a repeated START, stop early, or clock a fourth byte in place of STOP. After each command the master reads back the flags with a query, and also checks them on the flag outputs.

// File: rtl/wp_pkg.sv
package wp_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic shiftEn;   // capture SDA on SCL rise
    logic armHv;     // START seen: re-arm the high-voltage qualifier
    logic commit;    // STOP after a fully acknowledged write
  } wpStrobe_t;

  // datapath -> control decode results
  typedef struct packed {
    logic isOurs;      // device-type field matches the protection preamble
    logic isRead;      // address LSB
    logic selFlagSet;  // flag chosen by the query is set
    logic rejectWrite; // reversible write blocked by the sticky flag
  } wpStatus_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXEND, ST_ACK, ST_HOLD
  } wpState_t;
endpackage

// File: rtl/wp_flags.sv
module wp_flags
  import wp_pkg::*;
#(
  parameter int PIN_W = 3,
  parameter int BYTE_BITS = 8,
  parameter int TYPE_W = 4,
  parameter logic [TYPE_W-1:0] DEV_TYPE = 4'b0110,
  parameter logic [PIN_W-1:0] PAT_SET = 3'b001,
  parameter logic [PIN_W-1:0] PAT_CLR = 3'b011,
  parameter logic [PIN_W-1:0] PAT_QRY = 3'b101
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdaIn,
  input  logic [PIN_W-1:0] pins,
  input  logic             hvDetect,
  input  wpStrobe_t        strobe,
  output wpStatus_t        status,
  output logic             permFlag,
  output logic             revFlag
);
  localparam int TYPE_LSB = BYTE_BITS - TYPE_W;

  logic [BYTE_BITS-1:0] shiftReg;
  logic hvOk;
  logic revMode, revSetSel, revClrSel, revQrySel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      hvOk <= 1'b0;
    end else begin
      if (strobe.shiftEn) shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaIn};
      if (strobe.armHv) hvOk <= hvDetect;
      else if (!hvDetect) hvOk <= 1'b0;
    end
  end

  // qualifier must have held since START and still be present now
  assign revMode   = hvOk && hvDetect;
  assign revSetSel = revMode && (pins == PAT_SET);
  assign revClrSel = revMode && (pins == PAT_CLR);
  assign revQrySel = revMode && (pins == PAT_QRY);

  assign status.isOurs      = (shiftReg[BYTE_BITS-1:TYPE_LSB] == DEV_TYPE);
  assign status.isRead      = shiftReg[0];
  assign status.selFlagSet  = revQrySel ? revFlag : permFlag;
  assign status.rejectWrite = permFlag && (revSetSel || revClrSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      permFlag <= 1'b0;
      revFlag  <= 1'b0;
    end else if (strobe.commit) begin
      if (revSetSel || revClrSel) begin
        if (!permFlag) revFlag <= revSetSel;
      end else begin
        permFlag <= 1'b1;
      end
    end
  end

  // R7: sticky flag never drops
  assert_perm_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    permFlag |=> permFlag);
  // R8: reversible flag frozen while sticky flag is set
  assert_rev_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    permFlag |=> $stable(revFlag));
  // R9: flags move only on a commit strobe
  assert_commit_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> ($stable(revFlag) && $stable(permFlag)));
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int BYTE_BITS = 8,
  parameter int WRITE_BYTES = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  wpStatus_t status,
  output wpStrobe_t strobe,
  output logic      sdaPull
);
  localparam int CNT_W = $clog2(BYTE_BITS);
  localparam int IDX_W = $clog2(WRITE_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WRITE_BYTES - 1);

  wpState_t state;
  logic sclQ, sdaQ;
  logic [CNT_W-1:0] bitCnt;
  logic [IDX_W-1:0] byteIdx;
  logic endAfterAck;
  logic sclRise, sclFall, startCond, stopCond;

  assign sclRise   = sclIn && !sclQ;
  assign sclFall   = !sclIn && sclQ;
  assign startCond = sclIn && sclQ && sdaQ && !sdaIn;
  assign stopCond  = sclIn && sclQ && !sdaQ && sdaIn;

  assign strobe.shiftEn = (state == ST_RX) && sclRise;
  assign strobe.armHv   = startCond;
  assign strobe.commit  = stopCond && (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
      state <= ST_IDLE;
      bitCnt <= '0;
      byteIdx <= '0;
      endAfterAck <= 1'b0;
      sdaPull <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (startCond) begin
        state <= ST_RX;
        bitCnt <= '0;
        byteIdx <= '0;
        sdaPull <= 1'b0;
      end else if (stopCond) begin
        state <= ST_IDLE;
        sdaPull <= 1'b0;
      end else begin
        case (state)
          ST_RX: if (sclRise) begin
            if (bitCnt == LAST_BIT) begin
              state <= ST_RXEND;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_RXEND: if (sclFall) begin
            if (byteIdx == '0) begin
              if (!status.isOurs) begin
                state <= ST_IDLE;
              end else begin
                sdaPull <= status.isRead ? !status.selFlagSet : 1'b1;
                endAfterAck <= status.isRead;
                state <= ST_ACK;
              end
            end else if (byteIdx == LAST_IDX) begin
              sdaPull <= !status.rejectWrite;
              endAfterAck <= status.rejectWrite;
              state <= ST_ACK;
            end else begin
              sdaPull <= 1'b1;
              endAfterAck <= 1'b0;
              state <= ST_ACK;
            end
          end
          ST_ACK: if (sclFall) begin
            sdaPull <= 1'b0;
            if (endAfterAck) state <= ST_IDLE;
            else if (byteIdx == LAST_IDX) state <= ST_HOLD;
            else begin
              byteIdx <= byteIdx + 1'b1;
              state <= ST_RX;
            end
          end
          ST_HOLD: if (sclFall) state <= ST_IDLE;  // extra clocking aborts
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R4: pull-down only inside an acknowledge slot
  assert_pull_in_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    sdaPull |-> (state == ST_ACK));
  // R10: pull-down moves only while SCL was low
  assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPull) |-> !$past(sclIn));
  // R2: foreign device type gets no acknowledge
  assert_foreign_no_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RXEND && sclFall && byteIdx == '0 && !status.isOurs) |=> !sdaPull);
endmodule

// File: rtl/wp_prot_handler.sv
module wp_prot_handler
  import wp_pkg::*;
#(
  parameter int PIN_W = 3,
  parameter logic [PIN_W-1:0] PAT_SET = 3'b001,
  parameter logic [PIN_W-1:0] PAT_CLR = 3'b011,
  parameter logic [PIN_W-1:0] PAT_QRY = 3'b101
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [PIN_W-1:0] addrPins,
  input  logic             hvDetect,
  output logic             sdaPullDown,
  output logic             permFlag,
  output logic             revFlag
);
  localparam int BYTE_BITS = 8;

  wpStrobe_t strobe;
  wpStatus_t status;

  wp_ctrl #(.BYTE_BITS(BYTE_BITS), .WRITE_BYTES(3)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .status(status), .strobe(strobe), .sdaPull(sdaPullDown)
  );

  wp_flags #(
    .PIN_W(PIN_W), .BYTE_BITS(BYTE_BITS), .TYPE_W(4), .DEV_TYPE(4'b0110),
    .PAT_SET(PAT_SET), .PAT_CLR(PAT_CLR), .PAT_QRY(PAT_QRY)
  ) uFlags (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .pins(addrPins),
    .hvDetect(hvDetect), .strobe(strobe), .status(status),
    .permFlag(permFlag), .revFlag(revFlag)
  );
endmodule

// File: tb/sim_wp_prot_handler.sv
module sim_wp_prot_handler;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclOut = 1'b1;
  logic sdaOut = 1'b1;
  logic [2:0] pins = 3'b000;
  logic hv = 1'b0;
  logic pullDown, permF, revF;
  wire sdaLine = sdaOut && !pullDown;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int r10Viol = 0;
  logic prevPull = 1'b0;
  logic prevScl = 1'b1;

  always #5 clk = ~clk;

  wp_prot_handler u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclOut), .sdaIn(sdaLine),
    .addrPins(pins), .hvDetect(hv), .sdaPullDown(pullDown),
    .permFlag(permF), .revFlag(revF)
  );

  // R10 monitor: pull-down must not move while SCL stays high
  always @(negedge clk) begin
    if (rstN && pullDown != prevPull && prevScl && sclOut) r10Viol++;
    prevPull = pullDown;
    prevScl = sclOut;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendStart;
    sdaOut = 1'b1; idle(2);
    sclOut = 1'b1; idle(3);
    sdaOut = 1'b0; idle(3);
    sclOut = 1'b0; idle(2);
  endtask

  task automatic sendStop;
    sdaOut = 1'b0; idle(2);
    sclOut = 1'b1; idle(3);
    sdaOut = 1'b1; idle(3);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaOut = b[i]; idle(2);
      sclOut = 1'b1; idle(4);
      sclOut = 1'b0; idle(2);
    end
    sdaOut = 1'b1; idle(2);
    sclOut = 1'b1; idle(2);
    acked = !sdaLine;
    idle(2);
    sclOut = 1'b0; idle(2);
  endtask

  task automatic doWrite(input logic [7:0] addrByte, input logic [2:0] p,
                         input logic hvStart, input logic hvMid, input logic extra,
                         output logic a0, output logic a1, output logic a2);
    logic dummy;
    pins = p; hv = hvStart; idle(4);
    sendStart;
    sendByte(addrByte, a0);
    hv = hvMid;
    sendByte(8'h5A, a1);
    sendByte(8'hC3, a2);
    if (extra) sendByte(8'hFF, dummy);
    sendStop;
    idle(4);
    hv = 1'b0; idle(4);
  endtask

  task automatic doQuery(input logic [2:0] p, input logic hvVal, output logic a);
    pins = p; hv = hvVal; idle(4);
    sendStart;
    sendByte(8'h61, a);
    sendStop;
    idle(4);
    hv = 1'b0; idle(4);
  endtask

  // entry: [8:7] op (0 write 0x60, 1 query 0x61, 2 foreign 0xA0), [6] hv,
  // [5:3] pins, [2] expected ack(s), [1] expected sticky, [0] expected reversible
  localparam int NVEC = 8;
  localparam logic [8:0] VEC [NVEC] = '{
    {2'd1, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0},
    {2'd1, 1'b1, 3'b101, 1'b1, 1'b0, 1'b0},
    {2'd0, 1'b1, 3'b001, 1'b1, 1'b0, 1'b1},
    {2'd1, 1'b1, 3'b101, 1'b0, 1'b0, 1'b1},
    {2'd1, 1'b0, 3'b101, 1'b1, 1'b0, 1'b1},
    {2'd0, 1'b1, 3'b011, 1'b1, 1'b0, 1'b0},
    {2'd2, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0},
    {2'd0, 1'b1, 3'b001, 1'b1, 1'b0, 1'b1}
  };

  initial begin
    logic a0, a1, a2, q;
    rstN = 1'b0; idle(4);
    rstN = 1'b1; idle(2);
    check("R1 sticky after reset", permF, 1'b0);
    check("R1 reversible after reset", revF, 1'b0);
    check("R1 pull released", pullDown, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      logic [8:0] e;
      string tag;
      e = VEC[v];
      case (e[8:7])
        2'd0: begin
          tag = "R5 write";
          doWrite(8'h60, e[5:3], e[6], e[6], 1'b0, a0, a1, a2);
          check(tag, a0 && a1 && a2, e[2]);
        end
        2'd1: begin
          tag = "R4 query";
          doQuery(e[5:3], e[6], q);
          check(tag, q, e[2]);
        end
        default: begin
          tag = "R2 foreign";
          doWrite(8'hA0, e[5:3], e[6], e[6], 1'b0, a0, a1, a2);
          check(tag, a0, e[2]);
        end
      endcase
      check({tag, " sticky"}, permF, e[1]);
      check({tag, " reversible"}, revF, e[0]);
    end
    // state now: sticky 0, reversible 1

    // R9: repeated START after dummy address aborts a clear
    pins = 3'b011; hv = 1'b1; idle(4);
    sendStart; sendByte(8'h60, a0); sendByte(8'h5A, a1);
    sendStart; sendStop; idle(4); hv = 1'b0; idle(4);
    check("R9 repeated start keeps reversible", revF, 1'b1);
    // R9: early STOP after address
    pins = 3'b011; hv = 1'b1; idle(4);
    sendStart; sendByte(8'h60, a0); sendStop; idle(4); hv = 1'b0; idle(4);
    check("R9 early stop keeps reversible", revF, 1'b1);
    check("R9 early stop keeps sticky", permF, 1'b0);

    // R11: extra byte in place of STOP
    doWrite(8'h60, 3'b011, 1'b1, 1'b1, 1'b1, a0, a1, a2);
    check("R11 extra byte keeps reversible", revF, 1'b1);
    check("R11 extra byte keeps sticky", permF, 1'b0);

    // R6 + R3: qualifier absent at START, raised later -> sticky set
    doWrite(8'h60, 3'b011, 1'b0, 1'b1, 1'b0, a0, a1, a2);
    check("R3 all three bytes acked", a0 && a1 && a2, 1'b1);
    check("R6 late qualifier sets sticky", permF, 1'b1);
    check("R6 late qualifier keeps reversible", revF, 1'b1);

    // R8: reversible clear rejected on last dummy byte
    doWrite(8'h60, 3'b011, 1'b1, 1'b1, 1'b0, a0, a1, a2);
    check("R8 address acked", a0, 1'b1);
    check("R8 dummy address acked", a1, 1'b1);
    check("R8 data byte nacked", a2, 1'b0);
    check("R8 reversible unchanged", revF, 1'b1);

    // R7: sticky stays set; query reports it by NACK
    doWrite(8'h60, 3'b001, 1'b1, 1'b1, 1'b0, a0, a1, a2);
    check("R7 sticky still set", permF, 1'b1);
    doQuery(3'b000, 1'b0, q);
    check("R4 query of set sticky nacks", q, 1'b0);
    doQuery(3'b101, 1'b1, q);
    check("R5 reversible query nacks when set", q, 1'b0);

    // R1: reset clears; R6: qualifier dropping mid-command -> sticky
    rstN = 1'b0; idle(3); rstN = 1'b1; idle(2);
    check("R1 reset clears sticky", permF, 1'b0);
    check("R1 reset clears reversible", revF, 1'b0);
    doWrite(8'h60, 3'b001, 1'b1, 1'b0, 1'b0, a0, a1, a2);
    check("R6 dropped qualifier sets sticky", permF, 1'b1);
    check("R6 dropped qualifier leaves reversible", revF, 1'b0);

    check("R10 pull changed only with SCL low", r10Viol == 0, 1'b1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule